// File: doc/BRIEF.md
# Keyed-Refresh Watchdog Timer

This block is a memory-mapped watchdog. Software selects an interval with a 4-bit code, turns the counter on, and must then refresh it at intervals with a write to the control word. That write counts only when it carries a 12-bit key together with a reload bit. If the interval runs out with no valid refresh, the block does one of two things, depending on an action field. It either pulses a system-reset output for one clock or raises a sticky interrupt-pending flag. Time is kept in half-second ticks from a clock divider, so one parameter adapts the block to any clock rate.

The register bus is a plain single-cycle port. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are high. Read data is combinational from `bus_addr`. A small state machine sequences the counter:

- **IDLE**: the watchdog is disabled.
- **COUNT**: the half-second ticks are being counted.
- **FIRE**: the single cycle in which the expiry action is taken.

The transitions are:

- **IDLE→COUNT** when the enable bit is written as 1.
- **COUNT→COUNT (restart)** on a valid refresh or a change of interval code.
- **COUNT→FIRE** on the last tick of the interval.
- **FIRE→COUNT** when the next interval begins.
- **any→IDLE** when the enable bit is written as 0.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, all three register words read 0, `sys_rst_o` and `irq_o` are low, and the watchdog is disabled.
- R2: Interval code 0 expires after 1 tick (0.5 s). The FIRE cycle begins `CYC_PER_TICK` × ticks clock edges after the edge that enabled or restarted the count.
- R3: Codes 1 to 6 select 2 × code ticks (1 to 6 s).
- R4: Codes 7 to 11 select 16, 20, 24, 28 and 32 ticks (8 to 16 s). Codes 12 to 15 select 32 ticks.
- R5: A write to the control word (offset 0x10) restarts the count from zero only if bit 0 is 1 and bits 12:1 equal 0xA57, so the full word is 0x14AF.
- R6: Any other value written to the control word leaves the count running undisturbed.
- R7: Writing 0 to the mode word stops the watchdog. No expiry follows.
- R8: A mode write that enables a disabled watchdog, or that changes the interval code while the watchdog is enabled, restarts the count.
- R9: On expiry with action 0x1, `sys_rst_o` is high for exactly one clock. With any other action value, the pending bit (configuration bit 8) and `irq_o` rise one clock after FIRE. Writing 1 to bit 8 clears them.
- R10: A valid refresh written in the very cycle that would otherwise expire wins. No expiry occurs, and a full new interval starts.
- R11: The layout is as follows. The control word is at 0x10 and always reads 0. The configuration word is at 0x14, with the action in bits 1:0 and pending in bit 8. The mode word is at 0x18, with enable in bit 0 and the code in bits 7:4. Other mode bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with `bus_sel`) |
| bus_addr | input | 8 | Byte offset of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| sys_rst_o | output | 1 | One-clock system-reset pulse on expiry |
| irq_o | output | 1 | Level interrupt, equals the pending bit |

## Verification
The refresh and the expiry can land in the same cycle. This happens when a keyed write arrives in the cycle where the last tick of the interval is counted. The bench enables a two-tick interval and counts clock cycles. It drives the refresh so that its write edge is the one that would enter FIRE. It then expects no reset pulse at that point and a full fresh interval measured from the refresh edge. Both the restart and the expiry would otherwise clear the counters, so only the observed timing shows which one took priority.

// File: rtl/kw_pkg.sv
package kw_pkg;
    localparam logic [7:0]  OFS_KICK   = 8'h10;
    localparam logic [7:0]  OFS_CFG    = 8'h14;
    localparam logic [7:0]  OFS_MODE   = 8'h18;
    localparam logic [11:0] KICK_KEY   = 12'hA57;
    localparam logic [1:0]  ACT_SYSRST = 2'b01;
    localparam int          TICK_W     = 6;   // holds the 32-tick maximum

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FIRE  = 2'd2
    } kw_state_e;
endpackage

// File: rtl/kw_tick_gen.sv
module kw_tick_gen #(
    parameter int CYC_PER_TICK = 12_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int PRE_W = (CYC_PER_TICK > 2) ? $clog2(CYC_PER_TICK) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(CYC_PER_TICK - 1);

    logic [PRE_W-1:0] pre_q;

    assign tick = run && (pre_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (!run || clr || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/kw_interval_lut.sv
module kw_interval_lut
    import kw_pkg::*;
(
    input  logic [3:0]        code,
    output logic [TICK_W-1:0] limit
);
    always_comb begin
        if (code == 4'd0)
            limit = TICK_W'(1);
        else if (code <= 4'd6)
            limit = TICK_W'({code, 1'b0});
        else if (code <= 4'd11)
            limit = TICK_W'({code, 2'b00} - 6'd12);
        else
            limit = TICK_W'(32);
    end
endmodule

// File: rtl/kw_expiry_fsm.sv
module kw_expiry_fsm
    import kw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_next,
    input  logic              restart,
    input  logic              tick,
    input  logic [TICK_W-1:0] limit,
    output logic              run,
    output logic              pre_clr,
    output logic              fire
);
    kw_state_e         state_q, state_d;
    logic [TICK_W-1:0] elapsed_q;
    logic              expire;

    assign expire = (state_q == ST_COUNT) && tick && !restart
                    && (elapsed_q == limit - 1'b1);

    always_comb begin
        state_d = state_q;
        if (!en_next)
            state_d = ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_COUNT;
                ST_COUNT: state_d = expire ? ST_FIRE : ST_COUNT;
                ST_FIRE:  state_d = ST_COUNT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            elapsed_q <= '0;
        else if (!en_next || restart || expire || state_q != ST_COUNT)
            elapsed_q <= '0;
        else if (tick)
            elapsed_q <= elapsed_q + 1'b1;
    end

    always_comb begin
        run     = (state_q == ST_COUNT);
        pre_clr = restart;
        fire    = (state_q == ST_FIRE);
    end

    // R10: a refresh in the expiring cycle keeps the machine out of FIRE
    a_r10_refresh_beats_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && en_next) |=> (state_q != ST_FIRE));
    // R2: tick count stays inside the selected interval
    a_r2_elapsed_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (elapsed_q < limit));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kw_pkg::*;
#(
    parameter int CYC_PER_TICK = 12_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sys_rst_o,
    output logic        irq_o
);
    logic              mode_en_q;
    logic [3:0]        mode_code_q;
    logic [1:0]        act_q;
    logic              pend_q;
    logic              wr, kick_ok, mode_wr, cfg_wr, en_next, restart;
    logic              run, pre_clr, tick, fire;
    logic [TICK_W-1:0] limit;

    assign wr      = bus_sel && bus_wr;
    assign kick_ok = wr && (bus_addr == OFS_KICK) && bus_wdata[0]
                     && (bus_wdata[12:1] == KICK_KEY);
    assign mode_wr = wr && (bus_addr == OFS_MODE);
    assign cfg_wr  = wr && (bus_addr == OFS_CFG);
    assign en_next = mode_wr ? bus_wdata[0] : mode_en_q;
    assign restart = kick_ok || (mode_wr && bus_wdata[0]
                     && (!mode_en_q || bus_wdata[7:4] != mode_code_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_en_q   <= 1'b0;
            mode_code_q <= 4'd0;
            act_q       <= 2'd0;
        end else begin
            if (mode_wr) begin
                mode_en_q   <= bus_wdata[0];
                mode_code_q <= bus_wdata[7:4];
            end
            if (cfg_wr)
                act_q <= bus_wdata[1:0];
        end
    end

    // set on interrupt-mode expiry wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (fire && act_q != ACT_SYSRST)
            pend_q <= 1'b1;
        else if (cfg_wr && bus_wdata[8])
            pend_q <= 1'b0;
    end

    always_comb begin
        unique case (bus_addr)
            OFS_CFG:  bus_rdata = {23'd0, pend_q, 6'd0, act_q};
            OFS_MODE: bus_rdata = {24'd0, mode_code_q, 3'd0, mode_en_q};
            default:  bus_rdata = 32'd0;
        endcase
    end

    assign sys_rst_o = fire && (act_q == ACT_SYSRST);
    assign irq_o     = pend_q;

    kw_tick_gen #(.CYC_PER_TICK(CYC_PER_TICK)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(pre_clr), .tick(tick)
    );

    kw_interval_lut u_lut (.code(mode_code_q), .limit(limit));

    kw_expiry_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en_next(en_next), .restart(restart),
        .tick(tick), .limit(limit), .run(run), .pre_clr(pre_clr), .fire(fire)
    );

    // R9: reset pulse lasts one clock
    a_r9_rst_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |=> !sys_rst_o);
    // R9: pending only rises after an expiry cycle
    a_r9_pend_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(fire));
    // R7: a disabled watchdog never expires
    a_r7_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en_q |-> !fire);
    // R6: a rejected control write does not disturb the pending flag
    a_r6_bad_kick_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_KICK && !kick_ok && !fire) |=> $stable(pend_q));
endmodule

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        sys_rst_o, irq_o;
    int          errors = 0, checks = 0;

    always #2.5 clk = ~clk;

    keyed_watchdog #(.CYC_PER_TICK(N)) u_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_rst_o(sys_rst_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge (write edge between)
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #0.5; d = bus_rdata;
    endtask

    // counts negedges until an output rises; rst_seen reports which
    task automatic measure(input int max, output int n, output bit rst_seen);
        n = 0; rst_seen = 1'b0;
        while (n < max) begin
            @(negedge clk); n++;
            if (sys_rst_o) begin rst_seen = 1'b1; break; end
            if (irq_o) break;
        end
    endtask

    task automatic quiesce();
        wr(8'h18, 32'd0);
        wr(8'h14, 32'h100);
    endtask

    function automatic int ticks_for(input int code);
        if (code == 0) return 1;
        if (code <= 6) return 2 * code;
        if (code <= 11) return 4 * code - 12;
        return 32;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h10, d); check("R1 ctrl", int'(d), 0);
        rd(8'h14, d); check("R1 cfg", int'(d), 0);
        rd(8'h18, d); check("R1 mode", int'(d), 0);
        check("R1 rst out", int'(sys_rst_o), 0);
        check("R1 irq out", int'(irq_o), 0);
    endtask

    task automatic t_codes();
        int n; bit r;
        for (int c = 0; c < 16; c++) begin
            quiesce();
            wr(8'h14, 32'h1);
            wr(8'h18, 32'((c << 4) | 1));
            measure(200, n, r);
            check(c == 0 ? "R2 code0" : (c <= 6 ? "R3 code" : "R4 code"), n, N * ticks_for(c));
            check("R4 rst kind", int'(r), 1);
            @(negedge clk);
            check("R9 rst width", int'(sys_rst_o), 0);
        end
    endtask

    task automatic t_kick();
        int n; bit r;
        quiesce(); wr(8'h14, 32'h1); wr(8'h18, 32'h11);
        repeat (5) @(negedge clk);
        wr(8'h10, 32'h14AF);
        measure(100, n, r);
        check("R5 valid refresh", n, 8);
    endtask

    task automatic t_bad_kick();
        int n; bit r;
        quiesce(); wr(8'h14, 32'h1); wr(8'h18, 32'h11);
        repeat (5) @(negedge clk);
        wr(8'h10, 32'h14AE);
        wr(8'h10, 32'h14AD);
        measure(100, n, r);
        check("R6 bad refresh ignored", n, 1);
    endtask

    task automatic t_stop();
        int n; bit r; logic [31:0] d;
        quiesce(); wr(8'h14, 32'h1); wr(8'h18, 32'h01);
        @(negedge clk);
        wr(8'h18, 32'h0);
        measure(100, n, r);
        check("R7 stopped", n, 100);
        rd(8'h18, d); check("R7 mode reads 0", int'(d), 0);
    endtask

    task automatic t_code_change();
        int n; bit r;
        quiesce(); wr(8'h14, 32'h1); wr(8'h18, 32'h31);
        repeat (10) @(negedge clk);
        wr(8'h18, 32'h11);
        measure(100, n, r);
        check("R8 code change restart", n, 8);
    endtask

    task automatic t_irq();
        int n; bit r; logic [31:0] d;
        quiesce(); wr(8'h14, 32'h2); wr(8'h18, 32'h01);
        measure(100, n, r);
        check("R9 irq delay", n, N + 1);
        check("R9 no reset in irq mode", int'(r), 0);
        wr(8'h18, 32'h0);
        rd(8'h14, d); check("R9 pending bit", int'(d), 32'h102);
        wr(8'h14, 32'h102);
        check("R9 irq cleared", int'(irq_o), 0);
        rd(8'h14, d); check("R9 cfg after clear", int'(d), 32'h2);
    endtask

    task automatic t_collide();
        int n; bit r;
        quiesce(); wr(8'h14, 32'h1); wr(8'h18, 32'h11);
        repeat (7) @(negedge clk);
        wr(8'h10, 32'h14AF);
        check("R10 no pulse at collision", int'(sys_rst_o), 0);
        measure(100, n, r);
        check("R10 full interval after", n, 8);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        quiesce();
        wr(8'h18, 32'hFFFF_FFF0);
        rd(8'h18, d); check("R11 mode fields", int'(d), 32'hF0);
        wr(8'h14, 32'h3);
        rd(8'h14, d); check("R11 cfg action", int'(d), 32'h3);
        wr(8'h10, 32'h14AF);
        rd(8'h10, d); check("R11 ctrl reads 0", int'(d), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_codes();
        t_kick();
        t_bad_kick();
        t_stop();
        t_code_change();
        t_irq();
        t_collide();
        t_regs();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule